// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Address Generator

This block walks the word addresses of one DMA channel across a rectangular region. Software programs a start word address, a line length in words, a pitch in words between the starts of consecutive lines, and a line count minus one. A start pulse then launches the walk. The block offers one address per data beat on a valid/ready handshake and moves to the next address only when a beat is accepted. The direction bit and the burst-size bit travel with every beat.

A line length of zero selects a ring. The ring is a flat region of pitch × (lines) words that the block walks without end, jumping back to the start address after the last word. A half pulse marks the end of the first part and the end of the region. The half point is pitch × ((count minus one plus one) shifted right by one) words. The current address is always visible, so software can compute the remaining bytes from the distance travelled.

Top module: `strided_addr_gen`

## Requirements
- R1: After reset no beat is offered (`beat_valid_o` = 0), `finish_o` and `half_o` are 0, and `cur_addr_o` is 0.
- R2: In the idle state, a `start_i` pulse captures every configuration input, and the first beat offered on the next cycle carries `base_addr_i`. A `start_i` pulse while a walk is running is ignored.
- R3: With `line_words_i` ≠ 0 the block walks `lines_m1_i`+1 lines. Each line consists of `line_words_i` consecutive words, and line k starts at base + k × `pitch_i`.
- R4: An address advances only on a cycle where `beat_valid_o` and `beat_ready_i` are both 1. Otherwise `beat_addr_o` holds its value.
- R5: In the cycle after the last beat of the last line is accepted, `finish_o` is 1 for exactly one cycle and `beat_valid_o` is 0. `cur_addr_o` then points one step past the last word.
- R6: With `line_words_i` = 0, the address runs through pitch × (`lines_m1_i`+1) words from the base and then returns to the base. In this mode the walk never ends by itself and `finish_o` stays 0.
- R7: In ring mode, `half_o` is 1 for one cycle after the accepted beat that brings the position to pitch × ((`lines_m1_i`+1)>>1). It also pulses after the beat that completes the region.
- R8: A `loop_clear_i` or `abort_i` pulse stops the walk once the next beat is accepted, with no `finish_o` pulse. `loop_clear_i` has no effect outside ring mode.
- R9: With `burst_i` = 1, each beat covers 4 words and the address steps by 4, and `beat_burst_o` is 1. With `burst_i` = 0, each beat covers one word.
- R10: `beat_to_dev_o` equals the captured `to_dev_i` for every beat. The encoding is 1 for memory-to-device and 0 for device-to-memory.
- R11: `cur_addr_o` always equals the address of the beat currently offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launches a walk when the block is idle |
| base_addr_i | input | AW | Start word address (byte address >> 2) |
| line_words_i | input | LW | Words per line; 0 selects ring mode |
| pitch_i | input | LW | Words between the starts of consecutive lines |
| lines_m1_i | input | LW | Number of lines minus one |
| to_dev_i | input | 1 | 1 = memory to device, 0 = device to memory |
| burst_i | input | 1 | 1 = 4-word beats |
| loop_clear_i | input | 1 | Leaves ring mode at the next beat |
| abort_i | input | 1 | Stops any walk at the next beat |
| beat_ready_i | input | 1 | Downstream accepts the offered beat |
| beat_valid_o | output | 1 | A beat address is offered |
| beat_addr_o | output | AW | Word address of the offered beat |
| beat_to_dev_o | output | 1 | Direction of the walk |
| beat_burst_o | output | 1 | Offered beat covers 4 words |
| cur_addr_o | output | AW | Current address, for residue computation |
| finish_o | output | 1 | One-cycle pulse at the end of a linear walk |
| half_o | output | 1 | One-cycle pulse at each ring half boundary |

## Verification
The assertions assume that the pitch is at least 1 in ring mode, so the ring holds at least one word. They also assume that, in burst mode, the line length and the ring size are multiples of 4 words. The bench only launches walks whose parameters meet these conditions. It uses stalled and free-running ready patterns and issues stop and restart pulses only while a walk is in progress.

// File: rtl/sdma_addr_pkg.sv
package sdma_addr_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_e;
endpackage

// File: rtl/sdma_region_calc.sv
module sdma_region_calc #(
    parameter int LW = 12,
    parameter int PW = 2 * LW + 1
) (
    input  logic [LW-1:0] pitch_i,
    input  logic [LW-1:0] lines_m1_i,
    output logic [PW-1:0] total_o,
    output logic [PW-1:0] half_o
);
    logic [PW-1:0] lines;

    always_comb begin
        lines   = PW'(lines_m1_i) + PW'(1);
        total_o = PW'(pitch_i) * lines;
        half_o  = PW'(pitch_i) * (lines >> 1);
    end
endmodule

// File: rtl/sdma_addr_walker.sv
module sdma_addr_walker
    import sdma_addr_pkg::*;
#(
    parameter int AW          = 32,
    parameter int LW          = 12,
    parameter int PW          = 2 * LW + 1,
    parameter int BURST_WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic [LW-1:0] xlen_i,
    input  logic [LW-1:0] pitch_i,
    input  logic [LW-1:0] ylen_i,
    input  logic          dir_i,
    input  logic          burst_i,
    input  logic [PW-1:0] total_i,
    input  logic [PW-1:0] half_i,
    input  logic          loop_clear_i,
    input  logic          abort_i,
    input  logic          ready_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o,
    output logic          dir_o,
    output logic          burst_o,
    output logic          done_o,
    output logic          half_o
);
    typedef struct packed {
        run_e          st;
        logic [AW-1:0] addr;
        logic [AW-1:0] line_addr;
        logic [LW-1:0] col;
        logic [LW-1:0] row;
        logic [LW-1:0] xlen;
        logic [LW-1:0] pitch;
        logic [LW-1:0] ylen;
        logic [PW-1:0] pos;
        logic [PW-1:0] total;
        logic [PW-1:0] half;
        logic          loop_m;
        logic          dir;
        logic          burst;
        logic          stop;
        logic          done;
        logic          halfp;
    } walk_t;

    walk_t q, d;

    logic [LW:0]   step;
    logic [LW:0]   col_next;
    logic [PW-1:0] pos_next;
    logic          fire;
    logic          stop_now;
    logic          last;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.halfp  = 1'b0;
        step     = q.burst ? (LW+1)'(BURST_WORDS) : (LW+1)'(1);
        col_next = {1'b0, q.col} + step;
        pos_next = q.pos + PW'(step);
        fire     = (q.st == ST_RUN) && ready_i;
        stop_now = q.stop || abort_i || (loop_clear_i && q.loop_m);
        last     = 1'b0;

        if (q.st == ST_IDLE) begin
            if (start_i) begin
                d.st        = ST_RUN;
                d.addr      = base_i;
                d.line_addr = base_i;
                d.col       = '0;
                d.row       = '0;
                d.pos       = '0;
                d.xlen      = xlen_i;
                d.pitch     = pitch_i;
                d.ylen      = ylen_i;
                d.total     = total_i;
                d.half      = half_i;
                d.loop_m    = (xlen_i == '0);
                d.dir       = dir_i;
                d.burst     = burst_i;
                d.stop      = 1'b0;
            end
        end else begin
            if (stop_now) d.stop = 1'b1;
            if (fire) begin
                if (q.loop_m) begin
                    if (pos_next >= q.total) begin
                        d.addr  = q.line_addr;
                        d.pos   = '0;
                        d.halfp = 1'b1;
                    end else begin
                        d.addr  = q.addr + AW'(step);
                        d.pos   = pos_next;
                        d.halfp = (pos_next == q.half);
                    end
                end else if (col_next >= {1'b0, q.xlen}) begin
                    if (q.row == q.ylen) begin
                        last   = 1'b1;
                        d.addr = q.addr + AW'(step);
                    end else begin
                        d.row       = q.row + 1'b1;
                        d.col       = '0;
                        d.line_addr = q.line_addr + AW'(q.pitch);
                        d.addr      = q.line_addr + AW'(q.pitch);
                    end
                end else begin
                    d.col  = col_next[LW-1:0];
                    d.addr = q.addr + AW'(step);
                end
                if (stop_now) begin
                    d.st = ST_IDLE;
                end else if (last) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign valid_o = (q.st == ST_RUN);
    assign addr_o  = q.addr;
    assign dir_o   = q.dir;
    assign burst_o = q.burst;
    assign done_o  = q.done;
    assign half_o  = q.halfp;

    // Stalled beat keeps its address (R4)
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> $stable(addr_o));

    // Finish pulse follows an accepted beat and leaves the channel idle (R5)
    assert_done_after_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(valid_o && ready_i));
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !valid_o);

    // Ring position stays inside the region (R6)
    assert_ring_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && q.loop_m) |-> (q.pos < q.total));

    // Linear walk column stays inside the line (R3)
    assert_line_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !q.loop_m) |-> (q.col < q.xlen));

    // Half pulse only in ring mode after an accepted beat (R7)
    assert_half_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
        half_o |-> (q.loop_m && $past(valid_o && ready_i)));
endmodule

// File: rtl/strided_addr_gen.sv
module strided_addr_gen #(
    parameter int AW          = 32,
    parameter int LW          = 12,
    parameter int BURST_WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_addr_i,
    input  logic [LW-1:0] line_words_i,
    input  logic [LW-1:0] pitch_i,
    input  logic [LW-1:0] lines_m1_i,
    input  logic          to_dev_i,
    input  logic          burst_i,
    input  logic          loop_clear_i,
    input  logic          abort_i,
    input  logic          beat_ready_i,
    output logic          beat_valid_o,
    output logic [AW-1:0] beat_addr_o,
    output logic          beat_to_dev_o,
    output logic          beat_burst_o,
    output logic [AW-1:0] cur_addr_o,
    output logic          finish_o,
    output logic          half_o
);
    localparam int PW = 2 * LW + 1;

    logic [PW-1:0] region_total;
    logic [PW-1:0] region_half;

    sdma_region_calc #(.LW(LW), .PW(PW)) u_region (
        .pitch_i    (pitch_i),
        .lines_m1_i (lines_m1_i),
        .total_o    (region_total),
        .half_o     (region_half)
    );

    sdma_addr_walker #(.AW(AW), .LW(LW), .PW(PW), .BURST_WORDS(BURST_WORDS)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .base_i       (base_addr_i),
        .xlen_i       (line_words_i),
        .pitch_i      (pitch_i),
        .ylen_i       (lines_m1_i),
        .dir_i        (to_dev_i),
        .burst_i      (burst_i),
        .total_i      (region_total),
        .half_i       (region_half),
        .loop_clear_i (loop_clear_i),
        .abort_i      (abort_i),
        .ready_i      (beat_ready_i),
        .valid_o      (beat_valid_o),
        .addr_o       (beat_addr_o),
        .dir_o        (beat_to_dev_o),
        .burst_o      (beat_burst_o),
        .done_o       (finish_o),
        .half_o       (half_o)
    );

    assign cur_addr_o = beat_addr_o;
endmodule

// File: tb/strided_addr_gen_test.sv
`timescale 1ns/100ps
module strided_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base = '0;
    logic [11:0] xlen = '0, pitch = '0, ylen = '0;
    logic        to_dev = 1'b0, burst = 1'b0, loop_clear = 1'b0, abort = 1'b0, ready = 1'b0;
    logic        valid, bdir, bburst, fin, half;
    logic [31:0] baddr, caddr;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    strided_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base),
        .line_words_i(xlen), .pitch_i(pitch), .lines_m1_i(ylen),
        .to_dev_i(to_dev), .burst_i(burst), .loop_clear_i(loop_clear),
        .abort_i(abort), .beat_ready_i(ready), .beat_valid_o(valid),
        .beat_addr_o(baddr), .beat_to_dev_o(bdir), .beat_burst_o(bburst),
        .cur_addr_o(caddr), .finish_o(fin), .half_o(half)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic launch(input int b, input int x, input int p, input int y, input bit dr, input bit bu);
        @(negedge clk);
        base = b; xlen = x; pitch = p; ylen = y; to_dev = dr; burst = bu;
        ready = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        chk(valid == 1'b0, "R1 valid after reset", valid, 0);
        chk(fin == 1'b0 && half == 1'b0, "R1 pulses after reset", {fin, half}, 0);
        chk(caddr == 0, "R1 cur_addr after reset", caddr, 0);
    endtask

    // inject: 0 none, 1 loop_clear (R8 ignored), 2 restart (R2 ignored), 3 abort (R8)
    task automatic t_linear(input int b, input int x, input int p, input int y,
                            input bit dr, input bit bu, input bit stall, input int inject);
        int step = bu ? 4 : 1;
        int cyc = 0;
        int beat = 0;
        bit injected = 0;
        longint expa = 0;
        launch(b, x, p, y, dr, bu);
        for (int r = 0; r <= y; r++) begin
            for (int c = 0; c < x; c += step) begin
                expa = b + r * p + c;
                forever begin
                    cyc++;
                    ready = stall ? (cyc % 3 != 0) : 1'b1;
                    if (inject != 0 && beat == 1 && !injected) begin
                        injected = 1;
                        if (inject == 1) loop_clear = 1'b1;
                        if (inject == 2) begin start = 1'b1; base = b + 100; end
                        if (inject == 3) abort = 1'b1;
                    end
                    chk(valid == 1'b1 && baddr == expa, "R3 R4 beat address", baddr, expa);
                    chk(caddr == expa, "R11 current address", caddr, expa);
                    chk(bdir == dr && bburst == bu, "R10 R9 beat direction/burst", {bdir, bburst}, {dr, bu});
                    @(negedge clk);
                    loop_clear = 1'b0; start = 1'b0; abort = 1'b0;
                    if (ready) break;
                end
                beat++;
                if (inject == 3 && beat == 2) begin
                    ready = 1'b0;
                    chk(valid == 1'b0, "R8 abort stops after next beat", valid, 0);
                    chk(fin == 1'b0, "R8 abort gives no finish", fin, 0);
                    return;
                end
            end
        end
        ready = 1'b0;
        chk(fin == 1'b1, "R5 finish pulse", fin, 1);
        chk(valid == 1'b0, "R5 idle after finish", valid, 0);
        chk(caddr == expa + step, "R5 address past last word", caddr, expa + step);
        @(negedge clk);
        chk(fin == 1'b0, "R5 finish lasts one cycle", fin, 0);
    endtask

    // stop_kind: 0 loop_clear, 1 abort
    task automatic t_ring(input int b, input int p, input int y, input bit bu,
                          input int nb, input int stop_kind);
        int step = bu ? 4 : 1;
        int total = p * (y + 1);
        int hpt = p * ((y + 1) >> 1);
        int pos = 0;
        int cyc = 0;
        int npos;
        bit exp_half = 0;
        launch(b, 0, p, y, 1'b1, bu);
        for (int k = 0; k < nb; k++) begin
            forever begin
                cyc++;
                ready = (cyc % 4 != 0);
                chk(valid == 1'b1 && baddr == b + pos, "R6 ring address", baddr, b + pos);
                chk(half == exp_half, "R7 half pulse", half, exp_half);
                chk(fin == 1'b0, "R6 no finish in ring", fin, 0);
                @(negedge clk);
                if (ready) break;
                exp_half = 0;
            end
            npos = pos + step;
            exp_half = (npos == hpt) || (npos >= total);
            pos = (npos >= total) ? 0 : npos;
        end
        ready = 1'b0;
        if (stop_kind == 0) loop_clear = 1'b1; else abort = 1'b1;
        @(negedge clk);
        loop_clear = 1'b0; abort = 1'b0;
        chk(valid == 1'b1 && baddr == b + pos, "R8 stop waits for beat", baddr, b + pos);
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
        chk(valid == 1'b0, "R8 ring stopped", valid, 0);
        chk(fin == 1'b0, "R8 no finish on stop", fin, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linear(32'h100, 4, 10, 2, 1'b1, 1'b0, 1'b0, 0);   // R3 basic
        t_linear(32'h200, 5, 8, 3, 1'b0, 1'b0, 1'b1, 0);    // R4 stalls
        t_linear(32'h300, 8, 16, 1, 1'b1, 1'b1, 1'b1, 0);   // R9 burst
        t_linear(32'h400, 3, 3, 0, 1'b0, 1'b0, 1'b0, 0);    // single line
        t_linear(32'h500, 2, 6, 2, 1'b1, 1'b0, 1'b0, 1);    // R8 loop_clear ignored
        t_linear(32'h600, 3, 5, 2, 1'b0, 1'b0, 1'b1, 2);    // R2 restart ignored
        t_linear(32'h700, 4, 4, 3, 1'b1, 1'b0, 1'b0, 3);    // R8 abort
        t_ring(32'h800, 3, 3, 1'b0, 30, 0);                 // R6 R7 even lines
        t_ring(32'h900, 4, 2, 1'b0, 20, 1);                 // R7 odd lines
        t_ring(32'hA00, 8, 1, 1'b1, 10, 0);                 // R9 burst ring
        t_linear(32'hB00, 2, 2, 1, 1'b0, 1'b0, 1'b0, 0);    // R2 restart after ring
        summary();
    end
endmodule